// File: doc/BRIEF.md
# Output Port Group with Clock and Timer Outputs

This block is a memory-mapped output port made of three groups of output pins, each group as wide as the register bus. Every pin is driven from its own stored data bit. The first group has one drive-enable control per pin. The second and third groups each have one control that floats or drives the whole group. Software writes and reads the stores over a plain address/data/strobe bus. Reads are combinational.

Two pins of the first group can carry special signals instead of their data bits. The top pin can carry a clock picked from four sources: the low-speed clock divided by 64, the low-speed clock divided by 8, the low-speed clock itself, and the high-speed clock. The pin below it can carry a timer output that comes from outside. While a pin carries a special signal, its own float control still decides whether it drives. The hardware also keeps that pin's data bit at 1, so the pin drives high when the special function is switched off. The divided clocks come from a free-running counter that counts rising edges of the low-speed clock. A new frequency code takes effect only while both the old and the new source are low, so the clock pin never gives a short pulse.

Both clock inputs are level signals sampled in the `clk` domain. The high-speed input may toggle at most once per `clk` cycle.

Top module: `outport_special`

## Requirements
- R1: After reset every data store reads 4'b1111, every float control and the control register read 0, and all 12 pins drive high with output enable 1.
- R2: A write stores `bus_wdata` at `bus_addr`. The map is 0 = first-group float bits, 1 = first-group data, 2 = group float controls (bit 0 = second group, bit 1 = third group), 3 = second-group data, 4 = third-group data, 5 = control (bit 0 clock-output enable, bit 1 timer-output select, bits 3:2 frequency code). Unused bits and addresses 6 and 7 read 0.
- R3: Bit i of the first-group float register set to 1 clears `pin_oe[i]` for i = 0..3, and set to 0 it sets `pin_oe[i]`.
- R4: Bit 0 at address 2 clears `pin_oe[7:4]` together, and bit 1 clears `pin_oe[11:8]` together.
- R5: With no special function on a pin, `pin_out` bit 4g+i equals bit i of group g's data store.
- R6: With the clock-output enable at 1, `pin_out[3]` carries the selected clock and `pin_oe[3]` follows first-group float bit 3.
- R7: With the timer-output select at 1, `pin_out[2]` follows `timer_in` and `pin_oe[2]` follows first-group float bit 2.
- R8: While the clock-output enable is 1, first-group data bit 3 reads 1 whatever is written. While the timer-output select is 1, bit 2 reads 1 the same way. Both bits keep the value 1 after the special function is turned off.
- R9: Frequency code 0 gives a period of 64 low-speed periods, code 1 gives 8, code 2 gives 1, and code 3 passes the high-speed clock through.
- R10: A change of frequency code takes effect only at an edge where both the old and the new source are low. Every high pulse on the clock pin is therefore a full high phase of one source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 4 | Read data for `bus_addr` |
| slow_clk_in | input | 1 | Low-speed clock level, sampled on `clk` |
| fast_clk_in | input | 1 | High-speed clock level, sampled on `clk` |
| timer_in | input | 1 | Timer output routed to pin 2 |
| pin_out | output | 12 | Pin output values |
| pin_oe | output | 12 | Pin output enables (1 = drive) |

## Verification
The hardest condition to reach from the ports is a frequency-code write that lands while the clock pin is high, or while the new source is high. That is the case where a careless switch would cut a pulse short. The bench changes the code at fixed cycle offsets while a monitor measures the length of every high run on pin 3. It switches from a fast source to a slow one, from a slow one to a fast one, and between two divided taps. Each high run must match the half period of either the old or the new source. The periods themselves are measured between rising edges and compared with the source period times the division ratio.

// File: rtl/outport_pkg.sv
// Shared definitions for the output port group: register addresses and
// the control register layout. Assumes a 3-bit register address.
package outport_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_HIZ0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_DAT0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_HIZG = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAT1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_DAT2 = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;

    typedef enum logic [1:0] {
        FSEL_DIV64 = 2'd0,
        FSEL_DIV8  = 2'd1,
        FSEL_SLOW  = 2'd2,
        FSEL_FAST  = 2'd3
    } fsel_e;

    // Control register: [3:2] frequency code, [1] timer select, [0] clock enable
    typedef struct packed {
        fsel_e fsel;
        logic  tout_sel;
        logic  fout_en;
    } ctrl_t;
endpackage

// File: rtl/outport_regs.sv
// Register file of the port group. Holds three data stores, the float
// controls and the control register. Keeps the data bit of a pin in
// special use at 1. Assumes PORT_W >= 4 (the control word is 4 bits).
module outport_regs
    import outport_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PORT_W-1:0]    wdata,
    output logic [PORT_W-1:0]    rdata,
    output logic [PORT_W-1:0]    data0,
    output logic [PORT_W-1:0]    data1,
    output logic [PORT_W-1:0]    data2,
    output logic [PORT_W-1:0]    hiz0,
    output logic                 hiz1,
    output logic                 hiz2,
    output ctrl_t                ctrl
);
    localparam int CLK_BIT = PORT_W - 1;
    localparam int TMR_BIT = PORT_W - 2;

    ctrl_t             ctrl_nxt;
    logic [PORT_W-1:0] data0_nxt;

    // Next control word: replaced on a write to its address
    always_comb begin
        ctrl_nxt = ctrl;
        if (wr_en && addr == A_CTRL) ctrl_nxt = ctrl_t'(wdata[3:0]);
    end

    // Next first-group data: write, then pin special bits to 1
    always_comb begin
        data0_nxt = data0;
        if (wr_en && addr == A_DAT0) data0_nxt = wdata;
        if (ctrl_nxt.fout_en)  data0_nxt[CLK_BIT] = 1'b1;
        if (ctrl_nxt.tout_sel) data0_nxt[TMR_BIT] = 1'b1;
    end

    // Control register and first-group data store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            data0 <= '1;
        end else begin
            ctrl  <= ctrl_nxt;
            data0 <= data0_nxt;
        end
    end

    // Second and third group data stores
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data1 <= '1;
            data2 <= '1;
        end else if (wr_en) begin
            if (addr == A_DAT1) data1 <= wdata;
            if (addr == A_DAT2) data2 <= wdata;
        end
    end

    // Float controls, per pin for group 0 and per group for the others
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz0 <= '0;
            hiz1 <= 1'b0;
            hiz2 <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_HIZ0) hiz0 <= wdata;
            if (addr == A_HIZG) begin
                hiz1 <= wdata[0];
                hiz2 <= wdata[1];
            end
        end
    end

    // Read-back multiplexer, unused bits and addresses give 0
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_HIZ0: rdata = hiz0;
            A_DAT0: rdata = data0;
            A_HIZG: rdata[1:0] = {hiz2, hiz1};
            A_DAT1: rdata = data1;
            A_DAT2: rdata = data2;
            A_CTRL: rdata[3:0] = ctrl;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/outport_clkgen.sv
// Clock output generator: counts rising edges of the low-speed level with
// a free-running counter, taps two counter bits, and picks one of four
// sources. A new code is taken only while the old and the new source are
// both low. Assumes both clock levels are synchronous to clk.
module outport_clkgen
    import outport_pkg::*;
#(
    parameter int TAP_MID  = 2,
    parameter int TAP_SLOW = 5,
    parameter int DIV_W    = TAP_SLOW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_in,
    input  logic              fast_in,
    input  fsel_e             fsel,
    output logic              clk_out,
    output fsel_e             act_sel,
    output logic [DIV_W-1:0]  div_cnt
);
    localparam int NSRC = 4;

    logic            slow_q;
    logic            slow_rise;
    logic [NSRC-1:0] src;

    assign slow_rise = slow_in & ~slow_q;

    // Low-speed edge detector and free-running divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q  <= 1'b0;
            div_cnt <= '0;
        end else begin
            slow_q  <= slow_in;
            div_cnt <= div_cnt + {{(DIV_W-1){1'b0}}, slow_rise};
        end
    end

    // Candidate sources indexed by frequency code
    always_comb begin
        src[FSEL_DIV64] = div_cnt[TAP_SLOW];
        src[FSEL_DIV8]  = div_cnt[TAP_MID];
        src[FSEL_SLOW]  = slow_in;
        src[FSEL_FAST]  = fast_in;
    end

    // Active selection follows the code only at a common low phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_sel <= FSEL_DIV64;
        else if (fsel != act_sel && !src[act_sel] && !src[fsel])
            act_sel <= fsel;
    end

    assign clk_out = src[act_sel];
endmodule

// File: rtl/outport_pinmux.sv
// Pin multiplexer: maps data stores and float controls to pin values and
// enables, and routes the clock and timer outputs onto the top two pins
// of the first group. Purely combinational.
module outport_pinmux #(
    parameter int PORT_W = 4,
    parameter int NPIN   = 3 * PORT_W
) (
    input  logic [PORT_W-1:0] data0,
    input  logic [PORT_W-1:0] data1,
    input  logic [PORT_W-1:0] data2,
    input  logic [PORT_W-1:0] hiz0,
    input  logic              hiz1,
    input  logic              hiz2,
    input  logic              fout_en,
    input  logic              tout_sel,
    input  logic              clk_out,
    input  logic              timer_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    localparam int CLK_BIT = PORT_W - 1;
    localparam int TMR_BIT = PORT_W - 2;

    for (genvar i = 0; i < PORT_W; i++) begin : g_grp0
        if (i == CLK_BIT) begin : g_clk
            assign pin_out[i] = fout_en ? clk_out : data0[i];
        end else if (i == TMR_BIT) begin : g_tmr
            assign pin_out[i] = tout_sel ? timer_in : data0[i];
        end else begin : g_plain
            assign pin_out[i] = data0[i];
        end
        assign pin_oe[i] = ~hiz0[i];
    end

    assign pin_out[2*PORT_W-1:PORT_W]   = data1;
    assign pin_oe[2*PORT_W-1:PORT_W]    = {PORT_W{~hiz1}};
    assign pin_out[3*PORT_W-1:2*PORT_W] = data2;
    assign pin_oe[3*PORT_W-1:2*PORT_W]  = {PORT_W{~hiz2}};
endmodule

// File: rtl/outport_special.sv
// Top of the output port group with special outputs. Connects the
// register file, the clock output generator and the pin multiplexer.
module outport_special
    import outport_pkg::*;
#(
    parameter int PORT_W   = 4,
    parameter int TAP_MID  = 2,
    parameter int TAP_SLOW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PORT_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic                  slow_clk_in,
    input  logic                  fast_clk_in,
    input  logic                  timer_in,
    output logic [3*PORT_W-1:0]   pin_out,
    output logic [3*PORT_W-1:0]   pin_oe
);
    localparam int DIV_W = TAP_SLOW + 1;
    localparam int NPIN  = 3 * PORT_W;

    logic [PORT_W-1:0] data0, data1, data2, hiz0;
    logic              hiz1, hiz2, clk_out;
    ctrl_t             ctrl;
    fsel_e             act_sel;
    logic [DIV_W-1:0]  div_cnt;

    outport_regs #(.PORT_W(PORT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .data0 (data0),
        .data1 (data1),
        .data2 (data2),
        .hiz0  (hiz0),
        .hiz1  (hiz1),
        .hiz2  (hiz2),
        .ctrl  (ctrl)
    );

    outport_clkgen #(.TAP_MID(TAP_MID), .TAP_SLOW(TAP_SLOW), .DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_in (slow_clk_in),
        .fast_in (fast_clk_in),
        .fsel    (ctrl.fsel),
        .clk_out (clk_out),
        .act_sel (act_sel),
        .div_cnt (div_cnt)
    );

    outport_pinmux #(.PORT_W(PORT_W), .NPIN(NPIN)) u_pinmux (
        .data0    (data0),
        .data1    (data1),
        .data2    (data2),
        .hiz0     (hiz0),
        .hiz1     (hiz1),
        .hiz2     (hiz2),
        .fout_en  (ctrl.fout_en),
        .tout_sel (ctrl.tout_sel),
        .clk_out  (clk_out),
        .timer_in (timer_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );
endmodule

// File: rtl/outport_special_chk.sv
// Property checker for the output port group, bound to the top module.
// Observes ports and internal state of the top; drives nothing.
module outport_special_chk
    import outport_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int DIV_W  = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [PORT_W-1:0]     bus_wdata,
    input logic [PORT_W-1:0]     data0,
    input logic                  fout_en,
    input logic                  tout_sel,
    input logic [PORT_W-1:0]     hiz0,
    input logic                  timer_in,
    input logic [3*PORT_W-1:0]   pin_out,
    input logic [3*PORT_W-1:0]   pin_oe,
    input logic                  clk_out,
    input fsel_e                 act_sel,
    input logic [DIV_W-1:0]      div_cnt
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DAT0 && !fout_en && !tout_sel) |=> (data0 == $past(bus_wdata))); // R2

    AST_GROUP_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[2*PORT_W-1:PORT_W] == '0) || (pin_oe[2*PORT_W-1:PORT_W] == '1)); // R4

    AST_TIMER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_sel && !hiz0[PORT_W-2]) |-> (pin_oe[PORT_W-2] && pin_out[PORT_W-2] == timer_in)); // R7

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fout_en |-> data0[PORT_W-1]); // R8

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != $past(div_cnt)) |-> (div_cnt == $past(div_cnt) + 1'b1)); // R9

    AST_SWITCH_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |-> !$past(clk_out)); // R10
endmodule

bind outport_special outport_special_chk #(.PORT_W(PORT_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .data0     (data0),
    .fout_en   (ctrl.fout_en),
    .tout_sel  (ctrl.tout_sel),
    .hiz0      (hiz0),
    .timer_in  (timer_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .clk_out   (clk_out),
    .act_sel   (act_sel),
    .div_cnt   (div_cnt)
);

// File: tb/outport_special_tb.sv
`timescale 1ns/1ps
module outport_special_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_rdata;
    logic        slow_clk_in = 1'b0;
    logic        fast_clk_in = 1'b0;
    logic        timer_in = 1'b0;
    logic [11:0] pin_out, pin_oe;
    logic [1:0]  ph = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    outport_special u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .slow_clk_in(slow_clk_in),
        .fast_clk_in(fast_clk_in), .timer_in(timer_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #2.5 clk = ~clk;

    // Stimulus clocks: fast toggles every cycle, slow every second cycle (period 4)
    always @(negedge clk) begin
        fast_clk_in <= ~fast_clk_in;
        ph <= ph + 2'd1;
        if (ph[0]) slow_clk_in <= ~slow_clk_in;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    // Period between successive rising edges of pin 3, after one settling rise
    task automatic measure(output int period);
        int rises = 0, last = 0, cyc = 0;
        logic prev = 1'b1;
        period = -1;
        while (rises < 3 && cyc < 3000) begin
            @(posedge clk); #1;
            cyc++;
            if (!prev && pin_out[3]) begin
                rises++;
                if (rises == 3) period = cyc - last;
                last = cyc;
            end
            prev = pin_out[3];
        end
    endtask

    // Every completed high run on pin 3 must last a or b cycles
    task automatic watch(input int ncyc, input int a, input int b, input string req);
        int run = 0, odd = 0;
        bit seen_low = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(posedge clk); #1;
            if (pin_out[3]) run++;
            else begin
                if (seen_low && run != 0 && run != a && run != b) begin
                    odd++;
                    $display("FAIL %s actual=%0d expected=%0d or %0d", req, run, a, b);
                end
                run = 0;
                seen_low = 1;
            end
        end
        total++;
        if (odd != 0) bad++;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int v, p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(3'd1, v); check("R1 data0", v, 15);
        rd(3'd3, v); check("R1 data1", v, 15);
        rd(3'd4, v); check("R1 data2", v, 15);
        rd(3'd0, v); check("R1 hiz0", v, 0);
        rd(3'd2, v); check("R1 hizg", v, 0);
        rd(3'd5, v); check("R1 ctrl", v, 0);
        check("R1 pin_out", int'(pin_out), 12'hFFF);
        check("R1 pin_oe", int'(pin_oe), 12'hFFF);

        // R2: readback, unused bits and addresses
        wr(3'd2, 4'hF); rd(3'd2, v); check("R2 hizg unused bits", v, 3);
        wr(3'd2, 4'h0);
        wr(3'd6, 4'hF); rd(3'd6, v); check("R2 addr6", v, 0);
        rd(3'd7, v); check("R2 addr7", v, 0);
        wr(3'd5, 4'hC); rd(3'd5, v); check("R2 ctrl", v, 12);
        wr(3'd5, 4'h0);

        // R3: exhaustive first-group float sweep
        for (int k = 0; k < 16; k++) begin
            wr(3'd0, 4'(k)); #1;
            check("R3 oe0", int'(pin_oe[3:0]), (~k) & 15);
            rd(3'd0, v); check("R2 hiz0 readback", v, k);
        end
        wr(3'd0, 4'h0);

        // R4: group float controls
        for (int k = 0; k < 4; k++) begin
            wr(3'd2, 4'(k)); #1;
            check("R4 oe1", int'(pin_oe[7:4]), k[0] ? 0 : 15);
            check("R4 oe2", int'(pin_oe[11:8]), k[1] ? 0 : 15);
        end
        wr(3'd2, 4'h0);

        // R5: exhaustive data sweep per group
        for (int k = 0; k < 16; k++) begin
            wr(3'd1, 4'(k)); wr(3'd3, 4'((k + 5) & 15)); wr(3'd4, 4'(15 - k)); #1;
            check("R5 grp0", int'(pin_out[3:0]), k);
            check("R5 grp1", int'(pin_out[7:4]), (k + 5) & 15);
            check("R5 grp2", int'(pin_out[11:8]), 15 - k);
        end

        // R8: special use pins keep data bit at 1
        wr(3'd1, 4'h0);
        wr(3'd5, 4'h1); rd(3'd1, v); check("R8 set on enable", v, 8);
        wr(3'd1, 4'h0); rd(3'd1, v); check("R8 write held", v, 8);
        wr(3'd5, 4'h2); rd(3'd1, v); check("R8 timer bit", v, 12);
        wr(3'd1, 4'h0); rd(3'd1, v); check("R8 timer held", v, 4);
        wr(3'd5, 4'h0); #1; check("R8 pin2 high after off", int'(pin_out[2]), 1);
        wr(3'd1, 4'h0); rd(3'd1, v); check("R8 released", v, 0);

        // R7: timer routed to pin 2
        wr(3'd5, 4'h2);
        for (int k = 0; k < 4; k++) begin
            wr(3'd0, k[1] ? 4'h4 : 4'h0);
            @(negedge clk); timer_in = k[0]; #1;
            check("R7 pin2 value", int'(pin_out[2]), k[0]);
            check("R7 pin2 oe", int'(pin_oe[2]), k[1] ? 0 : 1);
        end
        wr(3'd0, 4'h0); wr(3'd5, 4'h0);

        // R6, R9: clock output periods per code (slow period 4, fast period 2)
        wr(3'd5, 4'h1); measure(p); check("R9 code0 /64", p, 256);
        wr(3'd5, 4'h5); measure(p); check("R9 code1 /8", p, 32);
        wr(3'd5, 4'h9); measure(p); check("R9 code2 slow", p, 4);
        wr(3'd5, 4'hD); measure(p); check("R9 code3 fast", p, 2);
        wr(3'd0, 4'h8); #1; check("R6 pin3 floated", int'(pin_oe[3]), 0);
        wr(3'd0, 4'h0); #1; check("R6 pin3 driven", int'(pin_oe[3]), 1);

        // R10: code changes at several offsets never cut a pulse short
        for (int off = 3; off < 40; off += 9) begin
            wr(3'd5, 4'hD); repeat (10) @(negedge clk);
            fork
                watch(200, 1, 16, "R10 fast to /8");
                begin repeat (off) @(negedge clk); wr(3'd5, 4'h5); end
            join
            fork
                watch(200, 16, 2, "R10 /8 to slow");
                begin repeat (off) @(negedge clk); wr(3'd5, 4'h9); end
            join
            fork
                watch(700, 2, 128, "R10 slow to /64");
                begin repeat (off) @(negedge clk); wr(3'd5, 4'h1); end
            join
            fork
                watch(700, 128, 16, "R10 /64 to /8");
                begin repeat (off + 100) @(negedge clk); wr(3'd5, 4'h5); end
            join
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule